// File: doc/BRIEF.md
# Biphase Mark Line Decoder

This block recovers a serial bit stream from one biphase-mark coded line. It runs on a single system clock that oversamples the line. The outputs are a data bit and a clock strobe, and together they can drive the serial clock and serial data inputs of an SPI-style shift-register receiver. In this code every bit cell begins with a line transition, and a logic one adds a second transition at mid-cell.

The decoder needs no free-running bit clock. Each cell-boundary transition starts a sample counter. When the counter reaches three quarters of a bit period, the line is sampled and compared with the sample taken one cell earlier. Equal samples give a one and different samples give a zero. After each sample the counter is held at its reload value. Only the next line edge releases it, so the timing is realigned on every bit. The bit period, in system clocks, is a parameter.

Top module: `bmc_decoder`

## Requirements
- R1: During and after a synchronous active-high reset, `data_o`, `strobe_o` and `los_o` are 0. The block then stays held with no strobe and no loss flag until a line edge arrives.
- R2: When a boundary edge on `bmc_i` is first registered on rising clock edge P1, `data_o` takes its new value on edge P1+SAMPLE_CLKS+2, where SAMPLE_CLKS = 3*BIT_CLKS/4. The line level used is the one present SAMPLE_CLKS clocks after the boundary.
- R3: The decoded bit is the XNOR of the current sample and the previous sample. Equal samples give 1 and different samples give 0. A correctly coded stream therefore yields 1 for a cell that has a mid-cell transition and 0 for a cell without one.
- R4: The first sample after reset or after a loss of signal produces no strobe and leaves `data_o` unchanged, because no previous sample exists yet.
- R5: `strobe_o` rises one clock after `data_o` updates and stays high for exactly one clock. `data_o` does not change in the cycle in which the strobe is high.
- R6: Line transitions that arrive while the sample counter is running, before the sample point, neither restart the counter nor change the decoded value.
- R7: After each sample the counter is held, and the first line edge after that restarts it. As a result, streams with bit periods a few clocks longer or shorter than BIT_CLKS (for example 15 or 18 against 16) decode without error.
- R8: In the held state with a valid previous sample, if no edge is seen for LOS_CLKS = 3*BIT_CLKS/2 clocks, `los_o` rises exactly LOS_CLKS clocks after the last strobe rose and the previous sample is discarded. The next edge clears `los_o`.
- R9: If a restarting edge is detected in the same cycle in which the loss timeout would expire, the edge wins. `los_o` stays 0, the previous sample is kept, and the next bit is decoded and strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bmc_i | input | 1 | Biphase-mark line, asynchronous to clk |
| data_o | output | 1 | Recovered data bit (serial data) |
| strobe_o | output | 1 | One-clock strobe, data valid at its rising edge (serial clock) |
| los_o | output | 1 | Loss-of-signal flag |

## Verification
Two events can fall in the same cycle: the loss-of-signal timeout and a restarting line edge. The bench provokes this by letting the line idle after a strobe and then placing one edge 21 clock periods after the strobe is seen, so that the synchronized edge reaches the decoder in the exact cycle in which the timeout counter would expire. It repeats the run with the edge one clock later. The first run must leave `los_o` at 0 and decode the next bit. The second must raise `los_o` and suppress that bit.

// File: rtl/bmc_dec_pkg.sv
package bmc_dec_pkg;

  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_RUN   = 2'd1,
    ST_LATCH = 2'd2
  } dec_state_t;

endpackage

// File: rtl/bmc_sync.sv
module bmc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic line_i,
  output logic line_s,
  output logic line_q
);

  // Shift chain with no reset: it only carries the line level.
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    chain <= {chain[STAGES-1:0], line_i};
  end

  assign line_s = chain[STAGES-1];
  assign line_q = chain[STAGES];

endmodule

// File: rtl/bmc_sample_timer.sv
module bmc_sample_timer #(
  parameter int LOAD = 12,
  localparam int W = $clog2(LOAD + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold,
  output logic [W-1:0] cnt_o,
  output logic         fire_o
);

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      cnt_o <= W'(LOAD - 1);
    end else if (cnt_o != '0) begin
      cnt_o <= cnt_o - 1'b1;
    end
  end

  assign fire_o = !hold && (cnt_o == '0);

endmodule

// File: rtl/bmc_idle_timer.sv
module bmc_idle_timer #(
  parameter int LIMIT = 24,
  localparam int W = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic expire_o
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
    end else if (cnt != W'(LIMIT - 1)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign expire_o = en && (cnt == W'(LIMIT - 1));

endmodule

// File: rtl/bmc_dec_ctrl.sv
module bmc_dec_ctrl
  import bmc_dec_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       line_s,
  input  logic       line_q,
  input  logic       fire_i,
  input  logic       expire_i,
  output dec_state_t state_o,
  output logic       idle_en_o,
  output logic       prev_valid_o,
  output logic       data_o,
  output logic       strobe_o,
  output logic       los_o
);

  dec_state_t state;
  logic       prev_smp;
  logic       prev_valid;
  logic       ref_lvl;
  logic       restart;

  // With a stored sample, any difference from it is an edge. Without one,
  // compare with the previous synchronized level.
  assign ref_lvl   = prev_valid ? prev_smp : line_q;
  assign restart   = (state == ST_HOLD) && (line_s != ref_lvl);
  assign idle_en_o = (state == ST_HOLD) && prev_valid && !restart;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_HOLD;
      prev_smp   <= 1'b0;
      prev_valid <= 1'b0;
      data_o     <= 1'b0;
      strobe_o   <= 1'b0;
      los_o      <= 1'b0;
    end else begin
      strobe_o <= 1'b0;
      unique case (state)
        ST_HOLD: begin
          if (restart) begin
            state <= ST_RUN;
            los_o <= 1'b0;
          end else if (expire_i) begin
            los_o      <= 1'b1;
            prev_valid <= 1'b0;
          end
        end
        ST_RUN: begin
          if (fire_i) begin
            state <= ST_LATCH;
            if (prev_valid) begin
              data_o <= ~(line_s ^ prev_smp);
            end
          end
        end
        ST_LATCH: begin
          prev_smp   <= line_s;
          prev_valid <= 1'b1;
          strobe_o   <= prev_valid;
          state      <= ST_HOLD;
        end
        default: state <= ST_HOLD;
      endcase
    end
  end

  assign state_o      = state;
  assign prev_valid_o = prev_valid;

endmodule

// File: rtl/bmc_decoder.sv
module bmc_decoder
  import bmc_dec_pkg::*;
#(
  parameter int BIT_CLKS    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bmc_i,
  output logic data_o,
  output logic strobe_o,
  output logic los_o
);

  localparam int SAMPLE_CLKS = (BIT_CLKS * 3) / 4;
  localparam int LOS_CLKS    = (BIT_CLKS * 3) / 2;
  localparam int SW          = $clog2(SAMPLE_CLKS + 1);

  logic          line_s;
  logic          line_q;
  logic [SW-1:0] samp_cnt;
  logic          fire;
  logic          expire;
  logic          idle_en;
  logic          prev_valid;
  dec_state_t    state;

  bmc_sync #(
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .line_i(bmc_i),
    .line_s(line_s),
    .line_q(line_q)
  );

  bmc_sample_timer #(
    .LOAD(SAMPLE_CLKS)
  ) u_samp (
    .clk   (clk),
    .rst   (rst),
    .hold  (state != ST_RUN),
    .cnt_o (samp_cnt),
    .fire_o(fire)
  );

  bmc_idle_timer #(
    .LIMIT(LOS_CLKS)
  ) u_idle (
    .clk     (clk),
    .rst     (rst),
    .en      (idle_en),
    .expire_o(expire)
  );

  bmc_dec_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .line_s      (line_s),
    .line_q      (line_q),
    .fire_i      (fire),
    .expire_i    (expire),
    .state_o     (state),
    .idle_en_o   (idle_en),
    .prev_valid_o(prev_valid),
    .data_o      (data_o),
    .strobe_o    (strobe_o),
    .los_o       (los_o)
  );

endmodule

// File: rtl/bmc_decoder_chk.sv
module bmc_decoder_chk
  import bmc_dec_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       data_o,
  input logic       strobe_o,
  input logic       los_o,
  input dec_state_t state,
  input logic       fire,
  input logic       prev_valid
);

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    strobe_o |=> !strobe_o); // R5

  AST_DATA_SETTLED: assert property (@(posedge clk) disable iff (rst)
    strobe_o |-> $stable(data_o)); // R5

  AST_STROBE_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    strobe_o |-> $past(fire, 2)); // R2

  AST_LOS_ONLY_HELD: assert property (@(posedge clk) disable iff (rst)
    $rose(los_o) |-> (state == ST_HOLD && !prev_valid)); // R8

  AST_SAMPLE_ENDS_RUN: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && fire) |=> (state == ST_LATCH)); // R7

endmodule

bind bmc_decoder bmc_decoder_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .data_o    (data_o),
  .strobe_o  (strobe_o),
  .los_o     (los_o),
  .state     (state),
  .fire      (fire),
  .prev_valid(prev_valid)
);

// File: tb/test_bmc_decoder.sv
module test_bmc_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int BIT        = 16;
  localparam int SAMP       = (BIT * 3) / 4;
  localparam int LOSC       = (BIT * 3) / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line = 1'b0;
  logic data_o, strobe_o, los_o;

  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 1'b0;
  int   cap_n   = 0;
  logic cap [0:63];
  bit   los_seen = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bmc_decoder #(.BIT_CLKS(BIT), .SYNC_STAGES(2)) i_bmc_decoder (
    .clk(clk), .rst(rst), .bmc_i(line),
    .data_o(data_o), .strobe_o(strobe_o), .los_o(los_o)
  );

  always @(negedge clk) begin
    if (strobe_o && cap_n < 64) begin
      cap[cap_n] = data_o;
      cap_n++;
    end
    if (los_o) los_seen = 1'b1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst  = 1'b1;
    line = 1'b0;
    wait_neg(6);
    rst = 1'b0;
    cap_n = 0;
    los_seen = 1'b0;
  endtask

  task automatic send_bit(input bit b, input int per);
    line = ~line;
    wait_neg(per / 2);
    if (b) line = ~line;
    wait_neg(per - per / 2);
  endtask

  task automatic send_stream(input logic [31:0] v, input int n, input int per);
    for (int i = 0; i < n; i++) send_bit(v[i], per);
  endtask

  // Decoded bits expected: all but the first bit sent after reset/LOS.
  task automatic check_stream(input logic [31:0] v, input int n, input string req);
    check(cap_n == n - 1, req, "strobe count", cap_n, n - 1);
    for (int i = 1; i < n && i <= cap_n; i++)
      check(cap[i-1] == v[i], req, $sformatf("bit %0d", i), cap[i-1], v[i]);
  endtask

  task automatic t_reset();  // R1
    do_reset();
    check(data_o == 0 && strobe_o == 0 && los_o == 0, "R1", "outputs after reset",
          {data_o, strobe_o, los_o}, 0);
    wait_neg(3 * BIT);
    check(cap_n == 0, "R1", "strobes while idle", cap_n, 0);
    check(!los_seen, "R1", "los while idle", los_seen, 0);
  endtask

  task automatic t_stream();  // R3, R4
    logic [31:0] v = 32'b0110_1001_1100_0101;
    do_reset();
    send_stream(v, 16, BIT);
    wait_neg(4);
    check_stream(v, 16, "R3");
    check(cap_n == 15, "R4", "first bit suppressed", cap_n, 15);
  endtask

  task automatic t_timing();  // R2, R5, R4
    do_reset();
    send_bit(1'b0, BIT);
    check(data_o == 0 && cap_n == 0, "R4", "no output for first bit", cap_n, 0);
    // second bit = 1, boundary edge now
    line = ~line;
    wait_neg(BIT / 2);
    line = ~line;
    wait_neg(SAMP + 2 - BIT / 2);
    check(data_o == 0, "R2", "data before sample point", data_o, 0);
    wait_neg(1);
    check(data_o == 1, "R2", "data at sample point", data_o, 1);
    check(strobe_o == 0, "R5", "strobe before data+1", strobe_o, 0);
    wait_neg(1);
    check(strobe_o == 1, "R5", "strobe one clock after data", strobe_o, 1);
    wait_neg(1);
    check(strobe_o == 0, "R5", "strobe width one clock", strobe_o, 0);
    check(data_o == 1, "R5", "data held after strobe", data_o, 1);
  endtask

  task automatic t_glitch();  // R6
    do_reset();
    send_bit(1'b1, BIT);
    for (int k = 0; k < 2; k++) begin
      line = ~line; wait_neg(2);
      line = ~line; wait_neg(2);
      line = ~line; wait_neg(BIT - 4);
      send_bit(1'b1, BIT);
    end
    wait_neg(4);
    check(cap_n == 4, "R6", "strobe count with early glitches", cap_n, 4);
    check(cap[0] == 0 && cap[1] == 1 && cap[2] == 0 && cap[3] == 1, "R6",
          "decoded with glitches", {cap[0], cap[1], cap[2], cap[3]}, 4'b0101);
  endtask

  task automatic t_resync();  // R7
    logic [31:0] v = 32'b1011_0010_1110_0110;
    do_reset();
    send_stream(v, 16, BIT - 1);
    wait_neg(4);
    check_stream(v, 16, "R7");
    do_reset();
    send_stream(~v, 16, BIT + 2);
    wait_neg(4);
    check_stream(~v, 16, "R7");
  endtask

  task automatic t_los();  // R8, R4
    do_reset();
    send_stream(32'b101, 3, BIT);  // returns on the negedge where the strobe is seen
    check(strobe_o == 1, "R8", "strobe before idle", strobe_o, 1);
    wait_neg(LOSC - 1);
    check(los_o == 0, "R8", "los one clock early", los_o, 0);
    wait_neg(1);
    check(los_o == 1, "R8", "los at timeout", los_o, 1);
    cap_n = 0;
    send_stream(32'b110, 3, BIT);
    wait_neg(4);
    check(los_o == 0, "R8", "los cleared by edge", los_o, 0);
    check_stream(32'b110, 3, "R8");
  endtask

  task automatic t_collide(input int gap, input bit expect_los);  // R9, R8
    do_reset();
    send_stream(32'b0101, 4, BIT);
    wait_neg(gap);
    cap_n = 0;
    los_seen = 1'b0;
    send_bit(1'b1, BIT);
    send_bit(1'b0, BIT);
    wait_neg(4);
    if (!expect_los) begin
      check(!los_seen, "R9", "no los when edge meets timeout", los_seen, 0);
      check(cap_n == 2, "R9", "bits kept after collision", cap_n, 2);
      check(cap_n >= 2 && cap[0] == 1 && cap[1] == 0, "R9", "values after collision",
            {cap[0], cap[1]}, 2'b10);
    end else begin
      check(los_seen, "R8", "los when edge one clock late", los_seen, 1);
      check(cap_n == 1 && cap[0] == 0, "R8", "first bit dropped after los",
            cap_n, 1);
    end
  endtask

  initial begin
    t_reset();
    t_stream();
    t_timing();
    t_glitch();
    t_resync();
    t_los();
    t_collide(LOSC - 3, 1'b0);
    t_collide(LOSC - 2, 1'b1);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule